// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block arbitrates interrupts for a small 4-bit processor core. Two sources feed it. One is an external pin, which is synchronised and edge-detected on a selectable polarity. The other is a single-cycle underflow pulse from a timer. Each source sets a sticky request flag. The flag stays set whether or not the source is enabled, and it is cleared only by servicing or by a polled skip test. An interrupt is taken when a request, its per-source enable bit and the global enable flag are all 1. The take happens at an instruction boundary. The controller then emits a take strobe and a vector address, and copies the core's data pointer, carry and skip flag into a one-deep shadow register.

The core supplies decoded strobes: enable-interrupts, disable-interrupts, one skip test per source, and an end-of-instruction marker. Each strobe is assumed to coincide with the end-of-instruction marker of the instruction that produces it. A global enable written by the enable strobe becomes active only after the next instruction completes. This lets the enable sit just before a return from an interrupt routine. A source whose enable bit is 0 is serviced by polling instead of by interrupt.

Top module: `irq_ctl`

## Requirements
- R1: A take occurs only when a source has its request flag, its enable bit and the global enable flag all at 1. A pending flag with either enable at 0 never produces a take.
- R2: The external source vectors to 0x080 and the timer source to 0x082. When both are eligible, the external source is taken first and the timer flag stays set.
- R3: A trigger sets its request flag even while the source or the global enable is off. The flag then stays set until a take or a valid skip test clears it.
- R4: A take clears the global enable flag and only the flag of the serviced source.
- R5: After the enable-interrupts strobe, the global enable flag becomes 1 only when the next instruction ends, and not at the end of the enabling instruction itself.
- R6: A skip test on a source is valid only while that source's enable bit is 0. A valid test raises skip_o when the flag is set and clears the flag. A test on an enabled source gives skip_o = 0 and leaves the flag unchanged.
- R7: Bit 2 of the control register selects the external edge: 0 = rising, 1 = falling. The pin passes through two synchroniser flops, and each qualifying edge sets the flag exactly once.
- R8: take_o rises 2 cycles after the take condition first holds. It rises 3 cycles after when the instruction running at that point lasts one cycle longer, that is, when insn_end is low in the cycle after the condition first holds.
- R9: On a take, dp_i, cy_i and skp_i as sampled at that clock edge appear on the shadow outputs together with take_o.
- R10: Reset clears the 4-bit control register (bit 0 = external enable, bit 1 = timer enable, bit 2 = edge select, bit 3 spare), both request flags, the global enable flag and take_o.
- R11: The disable-interrupts strobe clears the global enable flag and cancels an enable still waiting to become active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_uflow | input | 1 | Timer underflow pulse, one cycle per event |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wd | input | 4 | Control register write data |
| op_ei | input | 1 | Enable-interrupts instruction strobe |
| op_di | input | 1 | Disable-interrupts instruction strobe |
| op_skip_ext | input | 1 | Skip test on the external flag |
| op_skip_tmr | input | 1 | Skip test on the timer flag |
| insn_end | input | 1 | Last cycle of the current instruction |
| dp_i | input | DP_W | Core data pointer |
| cy_i | input | 1 | Core carry flag |
| skp_i | input | 1 | Core skip flag |
| take_o | output | 1 | One-cycle interrupt take strobe |
| vec_o | output | VEC_W | Vector of the last take |
| skip_o | output | 1 | Skip result of a valid skip test |
| gie_o | output | 1 | Global enable flag |
| req_o | output | 2 | Request flags (bit 0 external, bit 1 timer) |
| ctl_o | output | 4 | Control register contents |
| sh_dp_o | output | DP_W | Shadowed data pointer |
| sh_cy_o | output | 1 | Shadowed carry |
| sh_skp_o | output | 1 | Shadowed skip flag |

## Verification
Errors in the request flags show on req_o within one cycle of the trigger, skip test or take. A flag that is lost or cleared twice also shows as a missing or extra take, or as a wrong skip_o. A fault in the enable-delay or the take pipeline moves take_o by a cycle or more against the gie_o rise, so the bench counts cycles from that rise. Wrong arbitration or a stale shadow is caught when the scoreboard matches each take's vector and saved state with the item queued for it.

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int DP_W  = 6,
  parameter int VEC_W = 11,
  parameter logic [VEC_W-1:0] EXT_VEC = 11'h080,
  parameter logic [VEC_W-1:0] TMR_VEC = 11'h082
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             tmr_uflow,
  input  logic             ctl_we,
  input  logic [3:0]       ctl_wd,
  input  logic             op_ei,
  input  logic             op_di,
  input  logic             op_skip_ext,
  input  logic             op_skip_tmr,
  input  logic             insn_end,
  input  logic [DP_W-1:0]  dp_i,
  input  logic             cy_i,
  input  logic             skp_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             skip_o,
  output logic             gie_o,
  output logic [1:0]       req_o,
  output logic [3:0]       ctl_o,
  output logic [DP_W-1:0]  sh_dp_o,
  output logic             sh_cy_o,
  output logic             sh_skp_o
);

  logic [2:0] pin_s;
  logic [3:0] ctl_q;
  logic [1:0] req_q;
  logic       gie_q, arm_q, pend_q, take_q;

  wire rise     = pin_s[1] & ~pin_s[2];
  wire fall     = ~pin_s[1] & pin_s[2];
  wire ext_trig = ctl_q[2] ? fall : rise;

  wire [1:0] live   = req_q & ctl_q[1:0] & {2{gie_q}};
  wire       fire   = pend_q & (|live) & insn_end & ~take_q;
  wire       pick_x = live[0];

  wire sk_ext = op_skip_ext & ~ctl_q[0];
  wire sk_tmr = op_skip_tmr & ~ctl_q[1];

  wire [1:0] clr = {(fire & ~pick_x) | sk_tmr, (fire & pick_x) | sk_ext};

  assign skip_o = (sk_ext & req_q[0]) | (sk_tmr & req_q[1]);
  assign take_o = take_q;
  assign gie_o  = gie_q;
  assign req_o  = req_q;
  assign ctl_o  = ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s    <= '0;
      ctl_q    <= '0;
      req_q    <= '0;
      gie_q    <= 1'b0;
      arm_q    <= 1'b0;
      pend_q   <= 1'b0;
      take_q   <= 1'b0;
      vec_o    <= '0;
      sh_dp_o  <= '0;
      sh_cy_o  <= 1'b0;
      sh_skp_o <= 1'b0;
    end else begin
      pin_s  <= {pin_s[1:0], ext_pin};
      if (ctl_we) ctl_q <= ctl_wd;
      req_q  <= (req_q & ~clr) | {tmr_uflow, ext_trig};
      pend_q <= |live;
      take_q <= fire;

      if (fire | op_di)                    gie_q <= 1'b0;
      else if (arm_q & insn_end & ~op_ei)  gie_q <= 1'b1;

      if (fire | op_di)                    arm_q <= 1'b0;
      else if (op_ei & insn_end)           arm_q <= 1'b1;
      else if (insn_end)                   arm_q <= 1'b0;

      if (fire) begin
        vec_o    <= pick_x ? EXT_VEC : TMR_VEC;
        sh_dp_o  <= dp_i;
        sh_cy_o  <= cy_i;
        sh_skp_o <= skp_i;
      end
    end
  end

  // R1
  take_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(gie_o) && ($past(req_o & ctl_o[1:0]) != 2'b00));
  // R2
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == TMR_VEC) |-> !$past(req_o[0] & ctl_o[0]));
  // R4
  take_gie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !gie_o);
  // R5
  ei_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie_o) |-> $past(insn_end) && !$past(op_ei));
  // R6
  skip_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |-> (op_skip_ext && !ctl_o[0]) || (op_skip_tmr && !ctl_o[1]));
  // R8
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

endmodule

// File: tb/sim_irq_ctl.sv
module sim_irq_ctl;
  localparam int DP_W = 6;
  localparam int VEC_W = 11;
  localparam int IW = VEC_W + DP_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_pin = 0, tmr_uflow = 0, ctl_we = 0, op_ei = 0, op_di = 0;
  logic op_skip_ext = 0, op_skip_tmr = 0, insn_end = 1, cy_i = 0, skp_i = 0;
  logic [3:0] ctl_wd = '0;
  logic [DP_W-1:0] dp_i = '0;
  logic take_o, skip_o, gie_o, sh_cy_o, sh_skp_o;
  logic [VEC_W-1:0] vec_o;
  logic [1:0] req_o;
  logic [3:0] ctl_o;
  logic [DP_W-1:0] sh_dp_o;

  int n_chk = 0, n_err = 0;
  logic [IW-1:0] exp_q[$];

  always #5 clk = ~clk;

  irq_ctl u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [VEC_W-1:0] v);
    exp_q.push_back({v, dp_i, cy_i, skp_i});
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_we = 1; ctl_wd = v; step(); ctl_we = 0;
  endtask

  task automatic pulse_pin;
    ext_pin = 1; step(5); ext_pin = 0; step(5);
  endtask

  task automatic ei_pulse;
    op_ei = 1; step(); op_ei = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && take_o) begin
      if (exp_q.size() == 0) check(0, "R1 unexpected take", vec_o, 0);
      else begin
        logic [IW-1:0] e;
        e = exp_q.pop_front();
        check({vec_o, sh_dp_o, sh_cy_o, sh_skp_o} == e, "R2/R9 take item",
              {vec_o, sh_dp_o, sh_cy_o, sh_skp_o}, e);
      end
    end
  end

  initial begin
    step(3); rst_n = 1; step();
    // R10
    check(ctl_o == 4'h0 && req_o == 2'b00 && !gie_o && !take_o, "R10 reset", {ctl_o, req_o, gie_o}, 0);

    // R3 R7 rising edge latched while masked
    pulse_pin();
    check(req_o == 2'b01, "R3 R7 flag set masked", req_o, 1);
    // R6 valid skip clears
    op_skip_ext = 1; #1;
    check(skip_o == 1, "R6 skip taken", skip_o, 1);
    step(); op_skip_ext = 0;
    check(req_o == 2'b00, "R6 skip clears", req_o, 0);
    op_skip_ext = 1; #1;
    check(skip_o == 0, "R6 skip on clear flag", skip_o, 0);
    step(); op_skip_ext = 0;

    // R3 timer flag latched, polled
    tmr_uflow = 1; step(); tmr_uflow = 0;
    check(req_o == 2'b10, "R3 timer flag", req_o, 2);
    op_skip_tmr = 1; #1;
    check(skip_o == 1, "R6 timer skip", skip_o, 1);
    step(); op_skip_tmr = 0;
    check(req_o == 2'b00, "R6 timer skip clears", req_o, 0);

    // enable both sources, gie off
    wr_ctl(4'b0011);
    check(ctl_o == 4'b0011, "R10 ctl write", ctl_o, 3);
    pulse_pin();
    op_skip_ext = 1; #1;
    check(skip_o == 0, "R6 skip invalid when enabled", skip_o, 0);
    step(); op_skip_ext = 0;
    check(req_o == 2'b01, "R6 flag kept", req_o, 1);
    tmr_uflow = 1; step(); tmr_uflow = 0; step(4);
    check(req_o == 2'b11 && !take_o, "R1 no take without gie", req_o, 3);

    // R5 R8 R2 R4
    dp_i = 6'h2A; cy_i = 1; skp_i = 0;
    push(11'h080);
    ei_pulse();
    check(gie_o == 0, "R5 gie not yet", gie_o, 0);
    step();
    check(gie_o == 1, "R5 gie after next insn", gie_o, 1);
    step();
    check(take_o == 0, "R8 no take at 1", take_o, 0);
    step();
    check(take_o == 1, "R8 take at 2", take_o, 1);
    check(req_o == 2'b10 && gie_o == 0, "R2 R4 ext first timer kept", {req_o, gie_o}, 4);

    // R8 multi-cycle, timer vector
    step(2);
    dp_i = 6'h15; cy_i = 0; skp_i = 1;
    push(11'h082);
    ei_pulse(); step();
    check(gie_o == 1, "R5 gie set", gie_o, 1);
    step();
    check(take_o == 0, "R8 multi 1", take_o, 0);
    insn_end = 0; step();
    check(take_o == 0, "R8 multi 2", take_o, 0);
    insn_end = 1; step();
    check(take_o == 1, "R8 multi take at 3", take_o, 1);
    check(req_o == 2'b00, "R4 timer flag cleared", req_o, 0);

    // R11
    step(2);
    pulse_pin();
    ei_pulse();
    op_di = 1; step(); op_di = 0; step(5);
    check(gie_o == 0 && req_o == 2'b01, "R11 di cancels ei", {gie_o, req_o}, 1);

    // R7 falling select
    wr_ctl(4'b0100);
    op_skip_ext = 1; step(); op_skip_ext = 0;
    ext_pin = 1; step(5);
    check(req_o == 2'b00, "R7 rising ignored", req_o, 0);
    ext_pin = 0; step(5);
    check(req_o == 2'b01, "R7 falling sets", req_o, 1);
    op_skip_ext = 1; step(); op_skip_ext = 0; step(5);
    check(req_o == 2'b00, "R7 set once", req_o, 0);

    // R1 gie on, source disabled
    wr_ctl(4'b0000);
    ei_pulse(); step();
    tmr_uflow = 1; step(); tmr_uflow = 0; step(4);
    check(req_o == 2'b10 && gie_o == 1 && !take_o, "R1 masked source", {req_o, gie_o}, 5);
    dp_i = 6'h07; cy_i = 1; skp_i = 1;
    push(11'h082);
    wr_ctl(4'b0010); step(6);
    check(exp_q.size() == 0, "R1 all takes seen", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule